// File: doc/BRIEF.md
# Mode-Switched Parallel Port Register Decoder

This block sits between a host register bus and the register file of an IEEE 1284 style parallel port. The port has several operating modes, and the meaning of each register offset depends on which mode is active. The block holds the extended control byte, whose top three bits are the mode field. From the current mode, the address and the read and write strobes, it drives one select line per register and returns the read data of the selected register to the host.

There are two register windows. The low window is eight offsets with address bit 10 clear. The high window is eight offsets with address bit 10 set. The mode field is a small state machine with eight named states:

- MODE_COMPAT (000) is the reset state, the standard forward-only printer port.
- MODE_BIDIR (001) is the bidirectional port.
- MODE_PPFIFO (010) is the port with a data FIFO.
- MODE_ECP (011) is the extended capabilities port.
- MODE_EPP (100) is the enhanced port.
- MODE_RSVD (101) is reserved.
- MODE_TEST (110) is the FIFO test mode.
- MODE_CONFIG (111) is the configuration mode.

There is one transition, LOAD. On a clock edge where the host writes high-window offset 2, the state moves to the written bits 7:5. On every other edge the state holds. The FIFOs, the cable handshakes and the run-length logic live outside this block. The block only tells them when they are addressed.

Top module: `ppd_regdec`

## Requirements
- R1: While reset is asserted, and after it is released, the stored extended control byte is 0x00, so the mode is MODE_COMPAT (000).
- R2: High offset 2 selects the extended control register (sel bit 11) in every mode, for reads and writes. A write stores the whole byte at the clock edge. The mode output is bits 7:5 of the stored byte. A read returns the stored byte.
- R3: Low offset 0 behaves as follows.
  - In modes 000 and 001 it selects the data port (sel bit 0) on a read or a write.
  - In mode 011 a write selects the ECP address FIFO (sel bit 1), and a read selects nothing.
  - In every other mode it selects nothing.
- R4: Low offset 1 selects status (sel bit 2) on a read only, in every mode; a write there selects nothing. Low offset 2 selects control (sel bit 3) on a read or a write, in every mode.
- R5: In mode 100, low offset 3 selects the EPP address port (sel bit 4), and low offsets 4 to 7 select the EPP data port (sel bit 5). In every other mode these offsets select nothing.
- R6: High offset 0 selects a different target in each of four modes. In every other mode it selects nothing.
  - Mode 010: the port data FIFO (sel bit 6), on a write only.
  - Mode 011: the ECP data FIFO (sel bit 7), on a read or a write.
  - Mode 110: the test FIFO (sel bit 8), on a read or a write.
  - Mode 111: configuration register A (sel bit 9), on a read only.
- R7: High offset 1 selects configuration register B (sel bit 10) on a read or a write, only in mode 111. High offsets 3 to 7 never select anything.
- R8: With no strobe, or at an offset that the current mode leaves unmapped, no select line is asserted and rdata is 0x00.
- R9: At most one select line is high at a time. During a read, rdata equals the read input of the selected register. Both FIFO data targets and the test FIFO return fifo_q.
- R10: Select lines and rdata follow the address, strobes and mode in the same cycle, with no register on the path. A new mode applies from the cycle after the extended control write. A write to any other offset leaves the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_hi | input | 1 | Address bit 10: 1 selects the high window |
| addr_off | input | 3 | Offset within the window |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe (never asserted together with rd_en) |
| wdata | input | 8 | Host write data |
| data_port_q | input | 8 | Read value of the data port |
| status_q | input | 8 | Read value of the status register |
| control_q | input | 8 | Read value of the control register |
| epp_addr_q | input | 8 | Read value of the EPP address port |
| epp_data_q | input | 8 | Read value of the EPP data port |
| fifo_q | input | 8 | Read value of the head of the ECP or test FIFO |
| cfga_q | input | 8 | Read value of configuration register A |
| cfgb_q | input | 8 | Read value of configuration register B |
| sel | output | 12 | One-hot register selects, bit mapping as in R2 to R7 |
| rdata | output | 8 | Read data returned to the host |
| mode | output | 3 | Current mode field |

## Verification
A wrong stored mode shows up in two ways. First, the mode output is wrong from the first cycle after the faulty edge. Second, at the same time the select lines at low offsets 0 and 3 to 7 and at high offsets 0 and 1 move to the wrong register or go dark. A corrupted low byte of the extended control register stays hidden until the next read of high offset 2. That read returns the wrong value in the cycle of the read itself.

The bench sweeps all sixteen offsets with both strobes in each of the eight modes. During the sweep it writes values with the inverted mode bits to every other offset. A mode that changes on a stray write therefore fails the mode comparison one cycle later.

// File: rtl/ppd_pkg.sv
package ppd_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned OFF_W  = 3;
    localparam int unsigned MODE_W = 3;
    localparam int unsigned NSEL   = 12;

    // select bit positions
    localparam int unsigned S_DATA   = 0;
    localparam int unsigned S_AFIFO  = 1;
    localparam int unsigned S_STATUS = 2;
    localparam int unsigned S_CTRL   = 3;
    localparam int unsigned S_EPPA   = 4;
    localparam int unsigned S_EPPD   = 5;
    localparam int unsigned S_CFIFO  = 6;
    localparam int unsigned S_DFIFO  = 7;
    localparam int unsigned S_TFIFO  = 8;
    localparam int unsigned S_CFGA   = 9;
    localparam int unsigned S_CFGB   = 10;
    localparam int unsigned S_ECR    = 11;

    // high-window offsets with a fixed meaning
    localparam logic [OFF_W-1:0] HI_FIFO_OFF = 3'd0;
    localparam logic [OFF_W-1:0] HI_CFGB_OFF = 3'd1;
    localparam logic [OFF_W-1:0] HI_ECR_OFF  = 3'd2;

    typedef enum logic [MODE_W-1:0] {
        MODE_COMPAT = 3'b000,
        MODE_BIDIR  = 3'b001,
        MODE_PPFIFO = 3'b010,
        MODE_ECP    = 3'b011,
        MODE_EPP    = 3'b100,
        MODE_RSVD   = 3'b101,
        MODE_TEST   = 3'b110,
        MODE_CONFIG = 3'b111
    } mode_e;

endpackage

// File: rtl/ppd_mode_reg.sv
module ppd_mode_reg
    import ppd_pkg::*;
#(
    parameter int unsigned DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ecr_wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] ecr_q,
    output mode_e         mode
);

    localparam int unsigned MODE_LSB = DW - MODE_W;

    mode_e                 mode_q, mode_d;
    logic [MODE_LSB-1:0]   low_q, low_d;

    // next-state: LOAD on a control write, otherwise hold
    always_comb begin
        mode_d = mode_q;
        low_d  = low_q;
        if (ecr_wr) begin
            mode_d = mode_e'(wdata[DW-1:MODE_LSB]);
            low_d  = wdata[MODE_LSB-1:0];
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_COMPAT;
            low_q  <= '0;
        end else begin
            mode_q <= mode_d;
            low_q  <= low_d;
        end
    end

    assign ecr_q = {mode_q, low_q};
    assign mode  = mode_q;

    p_reset_compat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ecr_q == '0));

    p_load_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ecr_wr |=> (ecr_q == $past(wdata)));

    p_hold_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ecr_wr |=> $stable(ecr_q));

endmodule

// File: rtl/ppd_sel_decode.sv
module ppd_sel_decode
    import ppd_pkg::*;
(
    input  logic             addr_hi,
    input  logic [OFF_W-1:0] addr_off,
    input  logic             rd_en,
    input  logic             wr_en,
    input  mode_e            mode,
    output logic [NSEL-1:0]  sel
);

    logic strobe;
    assign strobe = rd_en | wr_en;

    always_comb begin
        sel = '0;
        if (!addr_hi) begin
            unique case (addr_off)
                3'd0: begin
                    unique case (mode)
                        MODE_COMPAT,
                        MODE_BIDIR:  sel[S_DATA]  = strobe;
                        MODE_ECP:    sel[S_AFIFO] = wr_en;
                        default:     ;
                    endcase
                end
                3'd1: sel[S_STATUS] = rd_en;
                3'd2: sel[S_CTRL]   = strobe;
                3'd3: sel[S_EPPA]   = strobe && (mode == MODE_EPP);
                default: sel[S_EPPD] = strobe && (mode == MODE_EPP);
            endcase
        end else begin
            unique case (addr_off)
                HI_FIFO_OFF: begin
                    unique case (mode)
                        MODE_PPFIFO: sel[S_CFIFO] = wr_en;
                        MODE_ECP:    sel[S_DFIFO] = strobe;
                        MODE_TEST:   sel[S_TFIFO] = strobe;
                        MODE_CONFIG: sel[S_CFGA]  = rd_en;
                        default:     ;
                    endcase
                end
                HI_CFGB_OFF: sel[S_CFGB] = strobe && (mode == MODE_CONFIG);
                HI_ECR_OFF:  sel[S_ECR]  = strobe;
                default:     ;
            endcase
        end
    end

endmodule

// File: rtl/ppd_rd_mux.sv
module ppd_rd_mux
    import ppd_pkg::*;
#(
    parameter int unsigned DW = DATA_W
) (
    input  logic                     rd_en,
    input  logic [NSEL-1:0]          sel,
    input  logic [NSEL-1:0][DW-1:0]  src,
    output logic [DW-1:0]            rdata
);

    logic [NSEL-1:0][DW-1:0] gated;

    for (genvar i = 0; i < NSEL; i++) begin : g_gate
        assign gated[i] = (rd_en && sel[i]) ? src[i] : '0;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NSEL; i++) begin
            rdata = rdata | gated[i];
        end
    end

endmodule

// File: rtl/ppd_regdec.sv
module ppd_regdec
    import ppd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               addr_hi,
    input  logic [OFF_W-1:0]   addr_off,
    input  logic               rd_en,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [DATA_W-1:0]  data_port_q,
    input  logic [DATA_W-1:0]  status_q,
    input  logic [DATA_W-1:0]  control_q,
    input  logic [DATA_W-1:0]  epp_addr_q,
    input  logic [DATA_W-1:0]  epp_data_q,
    input  logic [DATA_W-1:0]  fifo_q,
    input  logic [DATA_W-1:0]  cfga_q,
    input  logic [DATA_W-1:0]  cfgb_q,
    output logic [NSEL-1:0]    sel,
    output logic [DATA_W-1:0]  rdata,
    output logic [MODE_W-1:0]  mode
);

    mode_e                      mode_s;
    logic [DATA_W-1:0]          ecr_q;
    logic                       ecr_wr;
    logic [NSEL-1:0][DATA_W-1:0] src;

    ppd_mode_reg #(.DW(DATA_W)) u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .ecr_wr (ecr_wr),
        .wdata  (wdata),
        .ecr_q  (ecr_q),
        .mode   (mode_s)
    );

    ppd_sel_decode u_dec (
        .addr_hi  (addr_hi),
        .addr_off (addr_off),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .mode     (mode_s),
        .sel      (sel)
    );

    assign ecr_wr = wr_en & sel[S_ECR];

    always_comb begin
        src          = '0;
        src[S_DATA]  = data_port_q;
        src[S_STATUS]= status_q;
        src[S_CTRL]  = control_q;
        src[S_EPPA]  = epp_addr_q;
        src[S_EPPD]  = epp_data_q;
        src[S_DFIFO] = fifo_q;
        src[S_TFIFO] = fifo_q;
        src[S_CFGA]  = cfga_q;
        src[S_CFGB]  = cfgb_q;
        src[S_ECR]   = ecr_q;
    end

    ppd_rd_mux #(.DW(DATA_W)) u_mux (
        .rd_en (rd_en),
        .sel   (sel),
        .src   (src),
        .rdata (rdata)
    );

    assign mode = mode_s;

    p_onehot_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en || wr_en) |-> (sel == '0 && rdata == '0));

    p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == '0) |-> (rdata == '0));

    p_status_read_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en) |-> !sel[S_STATUS]);

    p_ecr_high_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sel[S_ECR] |-> (addr_hi && addr_off == HI_ECR_OFF));

    p_cfg_mode_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel[S_CFGA] || sel[S_CFGB]) |-> (mode == 3'b111));

endmodule

// File: tb/test_ppd_regdec.sv
module test_ppd_regdec;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_hi = 1'b0;
    logic [2:0]  addr_off = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [11:0] sel;
    logic [7:0]  rdata;
    logic [2:0]  mode;

    localparam logic [7:0] V_DATA = 8'hD1, V_STAT = 8'h5A, V_CTRL = 8'hC3,
                           V_EPPA = 8'h4E, V_EPPD = 8'hE7, V_FIFO = 8'h96,
                           V_CFGA = 8'h2B, V_CFGB = 8'hB8;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_ecr = 8'h00;   // reference copy of the control byte

    always #5 clk = ~clk;

    ppd_regdec i_ppd_regdec (
        .clk(clk), .rst_n(rst_n), .addr_hi(addr_hi), .addr_off(addr_off),
        .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata),
        .data_port_q(V_DATA), .status_q(V_STAT), .control_q(V_CTRL),
        .epp_addr_q(V_EPPA), .epp_data_q(V_EPPD), .fifo_q(V_FIFO),
        .cfga_q(V_CFGA), .cfgb_q(V_CFGB),
        .sel(sel), .rdata(rdata), .mode(mode)
    );

    // expected select bit, -1 for none; tag names the requirement
    function automatic int exp_idx(bit hi, bit [2:0] off, bit r, bit w,
                                   bit [2:0] m, output string tag);
        tag = "R8";
        if (!(r || w)) return -1;
        if (hi) begin
            if (off == 3'd2) begin tag = "R2"; return 11; end
            if (off == 3'd1) begin tag = "R7"; return (m == 3'b111) ? 10 : -1; end
            if (off == 3'd0) begin
                tag = "R6";
                if (m == 3'b010) return w ? 6 : -1;
                if (m == 3'b011) return 7;
                if (m == 3'b110) return 8;
                if (m == 3'b111) return r ? 9 : -1;
                return -1;
            end
            tag = "R7";
            return -1;
        end
        if (off == 3'd1) begin tag = "R4"; return r ? 2 : -1; end
        if (off == 3'd2) begin tag = "R4"; return 3; end
        if (off == 3'd0) begin
            tag = "R3";
            if (m == 3'b000 || m == 3'b001) return 0;
            if (m == 3'b011 && w) return 1;
            return -1;
        end
        tag = "R5";
        if (m != 3'b100) return -1;
        return (off == 3'd3) ? 4 : 5;
    endfunction

    function automatic logic [7:0] exp_rd(int idx, bit r);
        if (!r) return 8'h00;
        case (idx)
            0:  return V_DATA;
            2:  return V_STAT;
            3:  return V_CTRL;
            4:  return V_EPPA;
            5:  return V_EPPD;
            7, 8: return V_FIFO;
            9:  return V_CFGA;
            10: return V_CFGB;
            11: return m_ecr;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // one access: drive at negedge, compare mid-cycle, update model at the edge
    task automatic access(bit hi, bit [2:0] off, bit r, bit w, logic [7:0] d);
        string tag;
        int idx;
        logic [11:0] esel;
        @(negedge clk);
        addr_hi = hi; addr_off = off; rd_en = r; wr_en = w; wdata = d;
        #2;
        idx  = exp_idx(hi, off, r, w, m_ecr[7:5], tag);
        esel = (idx < 0) ? 12'h000 : (12'h001 << idx);
        chk(tag, "sel", 32'(sel), 32'(esel));
        chk((idx < 0) ? "R8" : "R9", "rdata", 32'(rdata), 32'(exp_rd(idx, r)));
        @(posedge clk);
        #1;
        if (w && hi && off == 3'd2) m_ecr = d;
        chk("R10", "mode", 32'(mode), 32'(m_ecr[7:5]));
        rd_en = 1'b0; wr_en = 1'b0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        chk("R1", "mode in reset", 32'(mode), 32'd0);
        rst_n = 1'b1;
        access(1'b1, 3'd2, 1'b1, 1'b0, 8'h00);   // R1: control byte reads 0x00
        access(1'b0, 3'd0, 1'b0, 1'b0, 8'hFF);   // R8: idle
        for (int m = 0; m < 8; m++) begin
            // R2: load mode via the high window
            access(1'b1, 3'd2, 1'b0, 1'b1, {3'(m), 5'(m * 5 + 1)});
            for (int a = 0; a < 16; a++) begin
                bit hi = a[3];
                bit [2:0] off = a[2:0];
                logic [7:0] d = (hi && off == 3'd2) ? {3'(m), 5'(a * 3 + m)}
                                                     : {~3'(m), 5'(a)};
                access(hi, off, 1'b1, 1'b0, 8'h00);
                access(hi, off, 1'b0, 1'b1, d);   // R10: stray writes keep mode
            end
        end
        // R1: reset in mid run brings back compatible mode
        access(1'b1, 3'd2, 1'b0, 1'b1, 8'hE5);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        m_ecr = 8'h00;
        chk("R1", "mode after reset", 32'(mode), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        access(1'b1, 3'd2, 1'b1, 1'b0, 8'h00);
        access(1'b0, 3'd4, 1'b1, 1'b0, 8'h00);   // R5: EPP data dark in compat
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule